// File: doc/BRIEF.md
# MDIO Management Interface Master

This block lets a host run management reads and writes on an external PHY over the two-wire MDC/MDIO bus. It builds MDC by dividing the system clock and holds it low whenever no transfer is running. It drives the shared MDIO line through separate output, output-enable and input signals. The pad-level tri-state buffer sits outside the block.

The host raises `req_valid` with an operation type, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. A request is taken only while `busy` is low. The block then serialises a fixed management frame in this order: an optional 32-bit run of ones, a start pattern, an operation code, both addresses, a turnaround pair and 16 data bits. In a read, the master releases the line for the turnaround and the data. It samples the second turnaround bit to detect a missing PHY. At the end it raises a one-cycle `done` with the read data already valid.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `mdc` is 0, `mdio_oe` is 0 and `busy` is 0.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0, and `busy` rises on that edge. A `req_valid` seen while `busy` is 1 changes neither the frame in progress nor the state that follows it.
- R3: With `req_no_pre` = 0, the frame opens with 32 driven ones, one per MDC period. With `req_no_pre` = 1, the frame opens directly with the start pattern.
- R4: After any preamble the master drives the start pattern 0,1 and then the operation code: 1,0 for a read (`req_read` = 1) or 0,1 for a write.
- R5: Next come the 5-bit PHY address and then the 5-bit register address, each driven most significant bit first.
- R6: In a write, the master drives the turnaround as 1,0 and then the 16 data bits, MSB first. In a read, `mdio_oe` is 0 for both turnaround bits and all 16 data bits.
- R7: Each MDC high phase and low phase lasts exactly DIV_HALF system clocks (10 by default, which gives 200 ns per half and a 400 ns period at 50 MHz). `mdio_o` and `mdio_oe` change only while MDC is low, and are updated at its falling edge.
- R8: In a read, `mdio_i` is sampled at each MDC rising edge of the 16 data bits. The bits are assembled MSB first and appear on `rd_data` in the cycle `done` is 1.
- R9: `done` is a single-cycle pulse. It is raised on the edge where `busy` falls, which is the falling MDC edge that ends the last data bit.
- R10: In a read, `no_ack` is set at `done` when the second turnaround bit was sampled as 1, and it is cleared when that bit was sampled as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while busy is low |
| req_read | input | 1 | 1 = read, 0 = write |
| req_no_pre | input | 1 | 1 = omit the 32-bit preamble |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data from the last read |
| no_ack | output | 1 | Last read saw no PHY on the second turnaround bit |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check on every cycle that MDC and the output enable stay quiet while idle. They also check that the MDIO output and its enable never move during an MDC high phase, that `done` lasts one cycle and coincides with `busy` falling, that `busy` only rises on a request, and that the divider count stays in range. Only the bench scenarios can show that the frame contents are right: the preamble with and without the skip flag, the operation codes, the address bit order, the turnaround and data of a write, and the release of the line in a read. The bench scenarios also cover the read data assembled from a PHY model, the missing-PHY flag, the exact MDC half-period lengths, and the fact that a request made mid-transfer leaves no trace.

// File: rtl/mdio_pkg.sv
// Shared constants and frame builder for the MDIO master.
// Assumes clause-22 style framing: 32-bit optional preamble, 32-bit body.
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int BODY_BITS  = 32;
    localparam int TOTAL_BITS = PRE_BITS + BODY_BITS;
    localparam int REM_W      = $clog2(TOTAL_BITS + 1);
    // bits remaining (inclusive) at which the turnaround and data begin
    localparam int REL_FROM   = 18;
    localparam int TA2_REM    = 17;
    localparam int DATA_REM   = 16;

    // Assemble the 32-bit body, first bit on the wire at bit 31.
    function automatic logic [BODY_BITS-1:0] build_body(
        input logic        rd,
        input logic [4:0]  phy,
        input logic [4:0]  regad,
        input logic [15:0] wd
    );
        logic [1:0]  opc;
        logic [1:0]  ta;
        logic [15:0] dat;
        opc = rd ? 2'b10 : 2'b01;
        ta  = rd ? 2'b00 : 2'b10;
        dat = rd ? 16'h0000 : wd;
        return {2'b01, opc, phy, regad, ta, dat};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: while run is high, toggles mdc every DIV_HALF system
// clocks, starting from the low phase. Flags the cycle on which mdc will
// rise or fall. Assumes run drops on the edge that ends a high phase.
module mdio_clkgen #(
    parameter int DIV_HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic tick_rise,
    output logic tick_fall
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end    = run && (cnt == CW'(DIV_HALF - 1));
    assign tick_rise = at_end && !mdc;
    assign tick_fall = at_end && mdc;

    // half-period counter and MDC toggle, parked low when not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (at_end) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DIV_HALF - 1));
    a_r7_half_len: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(at_end)) |-> $stable(mdc));
endmodule

// File: rtl/mdio_engine.sv
// Frame engine: loads the frame on an accepted request, presents one bit per
// MDC period (advancing on the falling edge), samples read data on the
// rising edge, and completes with a one-cycle done.
module mdio_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic        req_no_pre,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic        tick_rise,
    input  logic        tick_fall,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        no_ack,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [TOTAL_BITS-1:0] shreg;
    logic [REM_W-1:0]      rem;
    logic                  is_read;
    logic [15:0]           cap;
    logic                  ta_bad;
    logic [BODY_BITS-1:0]  body;

    assign body    = build_body(req_read, req_phy, req_reg, req_wdata);
    assign mdio_o  = busy && shreg[TOTAL_BITS-1];
    assign mdio_oe = busy && !(is_read && (rem <= REM_W'(REL_FROM)));

    // frame sequencing: load, shift on falling MDC, finish after last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            shreg   <= '0;
            rem     <= '0;
            is_read <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    busy    <= 1'b1;
                    is_read <= req_read;
                    shreg   <= req_no_pre ? {body, {PRE_BITS{1'b0}}}
                                          : {{PRE_BITS{1'b1}}, body};
                    rem     <= req_no_pre ? REM_W'(BODY_BITS) : REM_W'(TOTAL_BITS);
                end
            end else if (tick_fall) begin
                if (rem == REM_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    shreg <= shreg << 1;
                    rem   <= rem - 1'b1;
                end
            end
        end
    end

    // read capture on rising MDC: turnaround check and data shift-in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap    <= '0;
            ta_bad <= 1'b0;
        end else if (busy && is_read && tick_rise) begin
            if (rem == REM_W'(TA2_REM)) ta_bad <= mdio_i;
            if (rem <= REM_W'(DATA_REM)) cap <= {cap[14:0], mdio_i};
        end
    end

    // host-visible read results, updated when a read completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            no_ack  <= 1'b0;
        end else if (busy && is_read && tick_fall && rem == REM_W'(1)) begin
            rd_data <= cap;
            no_ack  <= ta_bad;
        end
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));
    a_r2_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

// File: rtl/mdio_master.sv
// MDIO management master top: ties the MDC generator to the frame engine.
// Assumes DIV_HALF system clocks per MDC half period meet the PHY's
// 160 ns half / 400 ns period minimums (10 at a 50 MHz system clock).
module mdio_master #(
    parameter int DIV_HALF = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic        req_no_pre,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        no_ack,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic tick_rise;
    logic tick_fall;

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    mdio_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_read   (req_read),
        .req_no_pre (req_no_pre),
        .req_phy    (req_phy),
        .req_reg    (req_reg),
        .req_wdata  (req_wdata),
        .tick_rise  (tick_rise),
        .tick_fall  (tick_fall),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .done       (done),
        .rd_data    (rd_data),
        .no_ack     (no_ack),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc && !mdio_oe);
    a_r7_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o) && $stable(mdio_oe));
endmodule

// File: tb/tb_mdio_master.sv
// Bench: directed corners plus seeded random transfers against a PHY model.
module tb_mdio_master;
    localparam int DIV_HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic        req_no_pre = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        mdio_i = 1'b1;
    logic        busy, done, no_ack, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // MDC phase-length and hold monitor (observes only)
    int hi_min = 1000, hi_max = 0, lo_min = 1000, lo_max = 0;
    int run_len = 0;
    int hold_bad = 0;
    logic prev_mdc = 0, prev_o = 0, prev_oe = 0;

    always #10 clk = ~clk;

    mdio_master #(.DIV_HALF(DIV_HALF)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_no_pre(req_no_pre), .req_phy(req_phy), .req_reg(req_reg),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .no_ack(no_ack), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always @(negedge clk) begin
        if (rst_n && (busy || prev_mdc)) begin
            if (mdc == prev_mdc) run_len++;
            else begin
                if (prev_mdc) begin
                    if (run_len < hi_min) hi_min = run_len;
                    if (run_len > hi_max) hi_max = run_len;
                end else if (run_len > 0) begin
                    if (run_len < lo_min) lo_min = run_len;
                    if (run_len > lo_max) lo_max = run_len;
                end
                run_len = 1;
            end
            if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe))
                hold_bad++;
        end else run_len = (busy && !mdc) ? 1 : 0;
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected body from the requirements: start, op, phy, reg, ta, data
    function automatic logic [31:0] exp_body(input bit rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] w);
        logic [31:0] b;
        b[31:30] = 2'b01;
        b[29:28] = rd ? 2'b10 : 2'b01;
        b[27:23] = p;
        b[22:18] = r;
        b[17:16] = rd ? 2'b00 : 2'b10;
        b[15:0]  = rd ? 16'h0 : w;
        return b;
    endfunction

    task automatic txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] w, input bit nopre, input bit ack,
                       input logic [15:0] phy_data, input bit poke);
        logic [31:0] eb;
        int nb, pre_bad, hdr_bad, adr_bad, td_bad, rel_bad, idle_bad;
        eb = exp_body(rd, p, r, w);
        nb = nopre ? 32 : 64;
        pre_bad = 0; hdr_bad = 0; adr_bad = 0; td_bad = 0; rel_bad = 0; idle_bad = 0;
        @(negedge clk);
        req_read = rd; req_phy = p; req_reg = r; req_wdata = w; req_no_pre = nopre;
        req_valid = 1'b1; mdio_i = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R2 busy after accept", busy, 1);
        for (int b = 0; b < nb; b++) begin
            int f;
            f = b - (nopre ? 0 : 32);
            // PHY model: releases first TA (pull-up), answers on second
            if (rd && f == 15) mdio_i = ack ? 1'b0 : 1'b1;
            else if (rd && f >= 16) mdio_i = ack ? phy_data[31-f] : 1'b1;
            else mdio_i = 1'b1;
            @(posedge mdc); #1;
            if (f < 0) begin
                if (mdio_oe !== 1'b1 || mdio_o !== 1'b1) pre_bad++;
            end else if (rd && f >= 14) begin
                if (mdio_oe !== 1'b0) rel_bad++;
            end else if (mdio_oe !== 1'b1 || mdio_o !== eb[31-f]) begin
                if (f < 4) hdr_bad++;
                else if (f < 14) adr_bad++;
                else td_bad++;
            end
            if (poke && b == 5) begin
                @(negedge clk);
                req_valid = 1'b1; req_read = !rd; req_phy = ~p; req_no_pre = !nopre;
                @(negedge clk);
                req_valid = 1'b0;
            end
            @(negedge mdc); #1;
        end
        chk(pre_bad == 0, "R3 preamble ones", pre_bad, 0);
        chk(hdr_bad == 0, "R4 start/op bits", hdr_bad, 0);
        chk(adr_bad == 0, "R5 address bits", adr_bad, 0);
        chk(td_bad + rel_bad == 0, "R6 turnaround/data/release", td_bad + rel_bad, 0);
        chk(done === 1'b1 && busy === 1'b0, "R9 done with busy low", {done, busy}, 2);
        if (rd) begin
            chk(rd_data === (ack ? phy_data : 16'hFFFF), "R8 read data", rd_data,
                ack ? phy_data : 16'hFFFF);
            chk(no_ack === !ack, "R10 no_ack flag", no_ack, !ack);
        end
        @(posedge clk); #1;
        chk(done === 1'b0, "R9 done one cycle", done, 0);
        for (int k = 0; k < 3 * DIV_HALF; k++) begin
            @(negedge clk);
            if (mdc || busy || mdio_oe) idle_bad++;
        end
        chk(idle_bad == 0, poke ? "R2 mid-frame request ignored" : "R1 idle quiet",
            idle_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk(busy === 0 && mdc === 0 && mdio_oe === 0 && done === 0, "R1 reset state",
            {busy, mdc, mdio_oe, done}, 0);
        @(negedge clk); rst_n = 1'b1;
        // directed corners
        txn(0, 5'd31, 5'd0,  16'h8001, 0, 1, 16'h0, 0);
        txn(1, 5'd1,  5'd31, 16'h0,    0, 1, 16'hA5C3, 0);
        txn(1, 5'd16, 5'd2,  16'h0,    1, 1, 16'h8001, 0);
        txn(1, 5'd3,  5'd4,  16'h0,    0, 0, 16'h1234, 0);
        txn(1, 5'd3,  5'd4,  16'h0,    1, 1, 16'h0000, 0);
        txn(0, 5'd0,  5'd21, 16'hFFFF, 1, 1, 16'h0, 0);
        txn(0, 5'd10, 5'd9,  16'h3C3C, 0, 1, 16'h0, 1);
        // seeded random mix
        for (int i = 0; i < 12; i++) begin
            bit rd_r, np_r, ack_r;
            rd_r  = $urandom_range(0, 1);
            np_r  = $urandom_range(0, 1);
            ack_r = ($urandom_range(0, 5) != 0);
            txn(rd_r, 5'($urandom), 5'($urandom), 16'($urandom), np_r, ack_r,
                16'($urandom), (i % 4) == 1);
        end
        chk(hi_min == DIV_HALF && hi_max == DIV_HALF, "R7 MDC high length", hi_max, DIV_HALF);
        chk(lo_min == DIV_HALF && lo_max == DIV_HALF, "R7 MDC low length", lo_max, DIV_HALF);
        chk(hold_bad == 0, "R7 MDIO stable while MDC high", hold_bad, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule